// File: doc/BRIEF.md
# Staged-Load Trace Clock Divider

This block turns a fast input clock into a slower trace clock with a 50% duty cycle. It also produces a one-cycle clock-enable that marks each rising edge of the trace clock. Software chooses the ratio through a small register port.

The ratio code is written into a pending register. Writing it has no effect on the output until software writes a separate load strobe. Two codes are legal: 1 gives divide-by-2 and 2 gives divide-by-4. A load with an illegal code (0 or 3) leaves the running ratio alone and raises a sticky error bit. An accepted ratio is held back until the trace clock's low phase ends, so the switch never produces a short pulse. A status register shows the code currently in force, which can differ from the pending one.

Register map (word address on `addr`):

- 0 holds the pending code in bits [1:0].
- 1 is the load strobe: writing 1 to bit 0 fires it.
- 2 is status: active code in bits [1:0] and the sticky error in bit 4.
- 3 reads as zero.

Top module: `trace_clkdiv_top`

## Requirements
- R1: Active code 1 gives a trace clock period of 2 input cycles and active code 2 gives 4 cycles, each with equal high and low phases.
- R2: A load while the pending code is 0 or 3 leaves the active code and the output rate unchanged.
- R3: After reset the pending code (address 0, bits [1:0]) reads 2, status reads active code 2 with error bit 4 clear, `trace_clk` is low and the block divides by 4.
- R4: Writing the pending code at address 0 without a later load does not change the active code or the output period.
- R5: Address 1 (load strobe) always reads 0.
- R6: An illegal load sets status bit 4, which stays set until a write to address 2 with bit 4 at 1 clears it.
- R7: A new active code takes effect only at the end of a low phase, so every trace clock period after a switch keeps equal high and low phases.
- R8: Status bits [1:0] report the code in force, not the pending code, until an accepted load has been applied.
- R9: `trace_ce` is high exactly in the cycles where `trace_clk` has just gone from low to high.
- R10: `rdata` shows the addressed register one cycle after `rd_en`, and is 0 in the cycle after no read; address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| trace_clk | output | 1 | Divided trace clock |
| trace_ce | output | 1 | One-cycle pulse at each trace clock rise |

## Verification
The bench writes a new code and then checks that the period and the status do not move, which catches a design that applies codes on write instead of on load. It loads both illegal codes to show that a design which accepts them, or which forgets the error bit, gives a wrong status or rate. It measures every period around a fast-to-slow and a slow-to-fast switch: a design that switches in the middle of a phase shows unequal high and low counts, and a misplaced enable shows up as a `trace_ce` pulse away from a rise.

// File: rtl/tcd_pkg.sv
package tcd_pkg;
  typedef enum logic [1:0] {
    DIVC_BAD0 = 2'd0,
    DIVC_FAST = 2'd1,
    DIVC_SLOW = 2'd2,
    DIVC_BAD3 = 2'd3
  } div_code_e;

  localparam int ADR_CODE   = 0;
  localparam int ADR_LOAD   = 1;
  localparam int ADR_STATUS = 2;
  localparam int ERR_BIT    = 4;

  function automatic logic code_ok(input logic [1:0] c);
    return (c == DIVC_FAST) || (c == DIVC_SLOW);
  endfunction
endpackage

// File: rtl/tcd_regs.sv
module tcd_regs
  import tcd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        act_code,
  output logic [DATA_W-1:0] rdata,
  output logic              load_v,
  output logic [1:0]        load_code
);
  logic [1:0] pend;
  logic       err;
  logic       wr_code, wr_load, wr_stat;

  assign wr_code = wr_en && (addr == ADDR_W'(ADR_CODE));
  assign wr_load = wr_en && (addr == ADDR_W'(ADR_LOAD)) && wdata[0];
  assign wr_stat = wr_en && (addr == ADDR_W'(ADR_STATUS));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= DIVC_SLOW;
      err       <= 1'b0;
      load_v    <= 1'b0;
      load_code <= DIVC_SLOW;
      rdata     <= '0;
    end else begin
      load_v <= 1'b0;
      if (wr_code) pend <= wdata[1:0];
      if (wr_stat && wdata[ERR_BIT]) err <= 1'b0;
      if (wr_load) begin
        if (code_ok(pend)) begin
          load_v    <= 1'b1;
          load_code <= pend;
        end else begin
          err <= 1'b1;
        end
      end
      rdata <= '0;
      if (rd_en) begin
        if (addr == ADDR_W'(ADR_CODE))
          rdata <= DATA_W'(pend);
        else if (addr == ADDR_W'(ADR_STATUS))
          rdata <= DATA_W'({err, 2'b00, act_code});
      end
    end
  end

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_code |=> $stable(pend)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err && !(wr_stat && wdata[ERR_BIT])) |=> err); // R6
  AST_LOAD_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(ADR_LOAD)) |=> (rdata == '0)); // R5
  AST_NO_BAD_LOAD: assert property (@(posedge clk) disable iff (rst)
    load_v |-> code_ok(load_code)); // R2
endmodule

// File: rtl/tcd_divider.sv
module tcd_divider
  import tcd_pkg::*;
#(
  parameter int DIV_FAST = 2,
  parameter int DIV_SLOW = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_v,
  input  logic [1:0] load_code,
  output logic [1:0] act_code,
  output logic       clk_o,
  output logic       ce_o
);
  localparam int HALF_FAST = DIV_FAST / 2;
  localparam int HALF_SLOW = DIV_SLOW / 2;
  localparam int CNT_W     = (HALF_SLOW > 1) ? $clog2(HALF_SLOW) : 1;

  logic [CNT_W-1:0] cnt, half_m1;
  logic [1:0]       nxt_code;
  logic             queued;

  assign half_m1 = (act_code == DIVC_FAST) ? CNT_W'(HALF_FAST - 1)
                                           : CNT_W'(HALF_SLOW - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      clk_o    <= 1'b0;
      ce_o     <= 1'b0;
      act_code <= DIVC_SLOW;
      nxt_code <= DIVC_SLOW;
      queued   <= 1'b0;
    end else begin
      ce_o <= 1'b0;
      if (cnt == half_m1) begin
        cnt   <= '0;
        clk_o <= ~clk_o;
        if (!clk_o) begin
          ce_o <= 1'b1;
          if (queued) begin
            act_code <= nxt_code;
            queued   <= 1'b0;
          end
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
      if (load_v) begin
        nxt_code <= load_code;
        queued   <= 1'b1;
      end
    end
  end

  AST_ACT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    code_ok(act_code)); // R2
  AST_SWITCH_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_code) |-> $rose(clk_o)); // R7
  AST_CE_ON_HIGH: assert property (@(posedge clk) disable iff (rst)
    ce_o |-> clk_o); // R9
endmodule

// File: rtl/trace_clkdiv_top.sv
module trace_clkdiv_top #(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 2,
  parameter int DIV_FAST = 2,
  parameter int DIV_SLOW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              trace_clk,
  output logic              trace_ce
);
  logic [1:0] act_code, load_code;
  logic       load_v;

  tcd_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .act_code(act_code), .rdata(rdata),
    .load_v(load_v), .load_code(load_code)
  );

  tcd_divider #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_div (
    .clk(clk), .rst(rst), .load_v(load_v), .load_code(load_code),
    .act_code(act_code), .clk_o(trace_clk), .ce_o(trace_ce)
  );
endmodule

// File: tb/sim_trace_clkdiv_top.sv
module sim_trace_clkdiv_top;
  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        trace_clk, trace_ce;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  trace_clkdiv_top u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .trace_clk(trace_clk), .trace_ce(trace_ce)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per completed read
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) chk(0, "scoreboard underflow", 0, 1);
      else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rdata === e, t, int'(rdata), int'(e));
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // one full trace period from a rise to the next rise, sampled at negedge
  task automatic measure(output int per, output int hi, output int ce_bad);
    logic prev;
    prev = trace_clk;
    @(negedge clk);
    while (!(prev == 1'b0 && trace_clk == 1'b1)) begin
      prev = trace_clk; @(negedge clk);
    end
    per = 0; hi = 0; ce_bad = (trace_ce !== 1'b1);
    do begin
      if (trace_clk) hi++;
      per++;
      prev = trace_clk;
      @(negedge clk);
      if (!(prev == 1'b0 && trace_clk == 1'b1) && trace_ce !== 1'b0) ce_bad++;
    end while (!(prev == 1'b0 && trace_clk == 1'b1));
    if (trace_ce !== 1'b1) ce_bad++;
  endtask

  task automatic expect_period(input int exp_per, input string t);
    int p, h, cb;
    measure(p, h, cb);
    chk(p == exp_per, {t, " period"}, p, exp_per);
    chk(2 * h == p, {t, " R7 duty"}, 2 * h, p);
    chk(cb == 0, {t, " R9 ce"}, cb, 0);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(trace_clk === 1'b0, "R3 trace_clk low", int'(trace_clk), 0);
    chk(trace_ce === 1'b0, "R9 ce low at reset", int'(trace_ce), 0);
    rd(2'd0, 16'h0002, "R3 pending code");
    rd(2'd2, 16'h0002, "R3 status");
    expect_period(4, "R3 R1 slow");

    // pending write only
    wr(2'd0, 16'h0001);
    rd(2'd0, 16'h0001, "R4 pending updated");
    rd(2'd2, 16'h0002, "R8 status unchanged");
    expect_period(4, "R4 rate held");

    // apply fast
    wr(2'd1, 16'h0001);
    rd(2'd1, 16'h0000, "R5 load reads 0");
    repeat (8) @(negedge clk);
    rd(2'd2, 16'h0001, "R8 status fast");
    for (int i = 0; i < 3; i++) expect_period(2, "R1 fast");

    // fast to slow switch, every period checked
    wr(2'd0, 16'h0002);
    wr(2'd1, 16'h0001);
    for (int i = 0; i < 4; i++) begin
      int p, h, cb;
      measure(p, h, cb);
      chk(p == 2 || p == 4, "R7 period legal", p, 4);
      chk(2 * h == p, "R7 no runt", 2 * h, p);
      chk(cb == 0, "R9 ce at rise", cb, 0);
    end
    expect_period(4, "R1 back to slow");

    // slow to fast switch while watching phases
    wr(2'd0, 16'h0001);
    wr(2'd1, 16'h0001);
    for (int i = 0; i < 4; i++) begin
      int p, h, cb;
      measure(p, h, cb);
      chk(2 * h == p, "R7 no runt up", 2 * h, p);
      chk(cb == 0, "R9 ce at rise up", cb, 0);
    end

    // illegal codes
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0001);
    repeat (8) @(negedge clk);
    rd(2'd2, 16'h0011, "R6 R2 err set code0");
    expect_period(2, "R2 rate kept code0");
    wr(2'd0, 16'h0003);
    wr(2'd1, 16'h0001);
    repeat (8) @(negedge clk);
    rd(2'd2, 16'h0011, "R2 err code3");
    expect_period(2, "R2 rate kept code3");
    wr(2'd2, 16'h0000);
    rd(2'd2, 16'h0011, "R6 sticky on zero write");
    wr(2'd2, 16'h0010);
    rd(2'd2, 16'h0001, "R6 cleared");

    // read port corners
    rd(2'd3, 16'h0000, "R10 addr3 zero");
    @(negedge clk);
    chk(rdata === 16'h0000, "R10 idle rdata", int'(rdata), 0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule